// File: doc/BRIEF.md
# PWM Double-Buffered Reload Controller

This block sits between a simple register bus and a PWM counter/comparator datapath. Software writes a prescaler divisor, a counter modulus and one duty value per channel into staging buffers. The active copies of these values, which drive the counter and comparators, change only at a PWM reload boundary. They change there only if a load-permission flag has been armed beforehand. The prescaler, the modulus and all duties move across together in one clock edge, so the datapath never sees a half-updated set.

The load-permission flag has a guarded arming rule. A control-register read that returns the flag as 0 arms the block. The next control write of 1 then sets the flag. A write of 1 that has no such read before it is ignored, and any other control write in between drops the arming. The flag clears itself once the transfer has happened. Software can also clear it before a reload, which cancels the transfer. The control register also holds the generator enable. With the enable clear, the generator is reported stopped and the output drivers are released unless the external override input is high. The reload strobe raises a one-cycle interrupt request whether or not a transfer took place.

The bus has no handshake. Every access completes in the cycle it is presented, and reads return data combinationally. No data stream crosses the block, so there is no back-pressure path. The reload strobe and the override are plain control levels.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: When the flag (control register at address 0, bit 0) is 1 in the cycle the reload strobe is high, the staged prescaler (address 1), modulus (address 2) and every channel duty (address 3 + channel) appear on the active outputs after that clock edge, all in the same cycle.
- R2: The flag is set only by a control write with bit 0 = 1 that follows a control read which returned bit 0 = 0. A write of 1 with no such read before it leaves the flag at 0.
- R3: After a transfer the flag reads 0 again, and the enable (control bit 1) keeps its value.
- R4: A control write with bit 0 = 0 clears the flag, and a reload that follows leaves the active values unchanged.
- R5: After reset the flag, the enable, all staged values, all active values and all output enables are 0.
- R6: With the enable set, the reload interrupt output is high for exactly the one cycle after each reload strobe, whatever the state of the flag.
- R7: Every output-enable bit (two per channel) is 1 when the enable bit or the override input is 1, and 0 otherwise. The generator-run output follows the enable bit.
- R8: Writes to the staged registers are accepted at any time, including while the flag is set, and read back immediately. The active outputs show them only after a transfer.
- R9: Any control write between the arming read and a write of 1 cancels the arming, so that later write of 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for arming) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| reload_i | input | 1 | Reload boundary strobe from the counter |
| out_ovr_i | input | 1 | Keeps output drivers enabled while the generator is off |
| act_prescale_o | output | PS_W | Active prescaler divisor |
| act_modulus_o | output | MOD_W | Active counter modulus |
| act_duty_o | output | N_CH*DUTY_W | Active duty values, channel c at bits c*DUTY_W upward |
| gen_run_o | output | 1 | Generator enable |
| pin_oe_o | output | 2*N_CH | Output driver enables, top and bottom per channel |
| reload_irq_o | output | 1 | Reload interrupt request, one cycle |

## Verification
The case hardest to reach from the ports is a stale arming. The bench has to produce a read-as-0, then another control write, and only then a write of 1, with no second read in between. The vector table places these accesses in sequence and confirms through a readback that the flag stayed 0. The table also sets the flag, clears it by a write, and then pulses the reload, showing at the active outputs that the cancel took effect. It stages a new modulus while the flag is set and shows that the new value becomes active only at the next reload.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  // register addresses
  localparam int unsigned ADDR_CTL   = 0;
  localparam int unsigned ADDR_PS    = 1;
  localparam int unsigned ADDR_MOD   = 2;
  localparam int unsigned ADDR_DUTY0 = 3;
  // control bit positions
  localparam int unsigned CTL_LOAD_BIT = 0;
  localparam int unsigned CTL_EN_BIT   = 1;
endpackage

// File: rtl/prc_stage_regs.sv
module prc_stage_regs
  import pwm_reload_pkg::*;
#(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned PS_W   = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [PS_W-1:0]          stg_ps_o,
  output logic [MOD_W-1:0]         stg_mod_o,
  output logic [N_CH*DUTY_W-1:0]   stg_duty_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam logic [ADDR_W-1:0] A_PS  = ADDR_W'(ADDR_PS);
  localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(ADDR_MOD);

  logic [DATA_W-1:0] duty_rd [N_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ps_o  <= '0;
      stg_mod_o <= '0;
    end else if (wr_i) begin
      if (addr_i == A_PS)  stg_ps_o  <= wdata_i[PS_W-1:0];
      if (addr_i == A_MOD) stg_mod_o <= wdata_i[MOD_W-1:0];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_duty
    localparam logic [ADDR_W-1:0] A_D = ADDR_W'(ADDR_DUTY0 + c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_duty_o[c*DUTY_W +: DUTY_W] <= '0;
      else if (wr_i && addr_i == A_D)
        stg_duty_o[c*DUTY_W +: DUTY_W] <= wdata_i[DUTY_W-1:0];
    end
    assign duty_rd[c] = (addr_i == A_D) ? DATA_W'(stg_duty_o[c*DUTY_W +: DUTY_W]) : '0;
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_PS)  rd_data_o = DATA_W'(stg_ps_o);
    if (addr_i == A_MOD) rd_data_o = DATA_W'(stg_mod_o);
    for (int c = 0; c < N_CH; c++) rd_data_o = rd_data_o | duty_rd[c];
  end
endmodule

// File: rtl/prc_load_arm.sv
module prc_load_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr_i,
  input  logic ctl_rd_i,
  input  logic wr_load_i,
  input  logic wr_en_i,
  input  logic reload_i,
  output logic load_q_o,
  output logic en_q_o,
  output logic xfer_o
);
  logic armed_q;

  assign xfer_o = reload_i && load_q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      load_q_o <= 1'b0;
      en_q_o   <= 1'b0;
    end else begin
      if (ctl_wr_i) begin
        en_q_o  <= wr_en_i;
        armed_q <= 1'b0;
        if (!wr_load_i)          load_q_o <= 1'b0;
        else if (armed_q)        load_q_o <= 1'b1;
        else if (xfer_o)         load_q_o <= 1'b0;
      end else begin
        if (ctl_rd_i && !load_q_o) armed_q <= 1'b1;
        if (xfer_o)                load_q_o <= 1'b0;
      end
    end
  end

  // R2
  load_arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_q_o) |-> $past(armed_q) && $past(ctl_wr_i) && $past(wr_load_i));

  // R3
  load_auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> !load_q_o);

  // R4
  load_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && !wr_load_i) |=> !load_q_o);
endmodule

// File: rtl/prc_active_regs.sv
module prc_active_regs #(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned PS_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   xfer_i,
  input  logic [PS_W-1:0]        stg_ps_i,
  input  logic [MOD_W-1:0]       stg_mod_i,
  input  logic [N_CH*DUTY_W-1:0] stg_duty_i,
  output logic [PS_W-1:0]        act_ps_o,
  output logic [MOD_W-1:0]       act_mod_o,
  output logic [N_CH*DUTY_W-1:0] act_duty_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ps_o  <= '0;
      act_mod_o <= '0;
    end else if (xfer_i) begin
      act_ps_o  <= stg_ps_i;
      act_mod_o <= stg_mod_i;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_duty_o[c*DUTY_W +: DUTY_W] <= '0;
      else if (xfer_i) act_duty_o[c*DUTY_W +: DUTY_W] <= stg_duty_i[c*DUTY_W +: DUTY_W];
    end
  end

  // R1
  xfer_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> (act_mod_o == $past(stg_mod_i)) && (act_ps_o == $past(stg_ps_i))
               && (act_duty_o == $past(stg_duty_i)));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(act_mod_o) && $stable(act_ps_o) && $stable(act_duty_o));
endmodule

// File: rtl/prc_out_ctrl.sv
module prc_out_ctrl #(
  parameter int unsigned N_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ovr_i,
  input  logic              reload_i,
  output logic [2*N_CH-1:0] pin_oe_o,
  output logic              gen_run_o,
  output logic              irq_o
);
  assign gen_run_o = en_i;

  for (genvar p = 0; p < 2*N_CH; p++) begin : g_oe
    assign pin_oe_o[p] = en_i | ovr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= reload_i && en_i;
  end

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && en_i) |=> irq_o);

  // R6
  irq_only_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(reload_i));
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned DUTY_W = 12,
  parameter int unsigned MOD_W  = 12,
  parameter int unsigned PS_W   = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   reload_i,
  input  logic                   out_ovr_i,
  output logic [PS_W-1:0]        act_prescale_o,
  output logic [MOD_W-1:0]       act_modulus_o,
  output logic [N_CH*DUTY_W-1:0] act_duty_o,
  output logic                   gen_run_o,
  output logic [2*N_CH-1:0]      pin_oe_o,
  output logic                   reload_irq_o
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);

  logic                   ctl_sel, load_q, en_q, xfer;
  logic [PS_W-1:0]        stg_ps;
  logic [MOD_W-1:0]       stg_mod;
  logic [N_CH*DUTY_W-1:0] stg_duty;
  logic [DATA_W-1:0]      stg_rd;

  assign ctl_sel = (bus_addr == A_CTL);

  prc_stage_regs #(.N_CH(N_CH), .DUTY_W(DUTY_W), .MOD_W(MOD_W), .PS_W(PS_W),
                   .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .stg_ps_o(stg_ps), .stg_mod_o(stg_mod), .stg_duty_o(stg_duty), .rd_data_o(stg_rd));

  prc_load_arm u_arm (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_i(bus_wr && ctl_sel), .ctl_rd_i(bus_rd && ctl_sel),
    .wr_load_i(bus_wdata[CTL_LOAD_BIT]), .wr_en_i(bus_wdata[CTL_EN_BIT]),
    .reload_i(reload_i), .load_q_o(load_q), .en_q_o(en_q), .xfer_o(xfer));

  prc_active_regs #(.N_CH(N_CH), .DUTY_W(DUTY_W), .MOD_W(MOD_W), .PS_W(PS_W)) u_act (
    .clk(clk), .rst_n(rst_n), .xfer_i(xfer),
    .stg_ps_i(stg_ps), .stg_mod_i(stg_mod), .stg_duty_i(stg_duty),
    .act_ps_o(act_prescale_o), .act_mod_o(act_modulus_o), .act_duty_o(act_duty_o));

  prc_out_ctrl #(.N_CH(N_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .ovr_i(out_ovr_i), .reload_i(reload_i),
    .pin_oe_o(pin_oe_o), .gen_run_o(gen_run_o), .irq_o(reload_irq_o));

  always_comb begin
    bus_rdata = stg_rd;
    if (ctl_sel) begin
      bus_rdata = '0;
      bus_rdata[CTL_LOAD_BIT] = load_q;
      bus_rdata[CTL_EN_BIT]   = en_q;
    end
  end
endmodule

// File: tb/test_pwm_reload_ctrl.sv
module test_pwm_reload_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 6, DUTY_W = 12, MOD_W = 12, PS_W = 2, ADDR_W = 4, DATA_W = 16;

  localparam logic [2:0] OP_WR = 0, OP_RD = 1, OP_RL = 2, OP_AM = 3, OP_AD = 4, OP_AP = 5;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int N_ROWS = 40;
  localparam vec_t TBL [N_ROWS] = '{
    '{OP_WR, 4'd2, 16'd100, 16'd0,   4'd8},  // R8 stage modulus
    '{OP_WR, 4'd3, 16'd40,  16'd0,   4'd8},  // R8 stage duty ch0
    '{OP_WR, 4'd8, 16'd77,  16'd0,   4'd8},  // R8 stage duty ch5
    '{OP_WR, 4'd1, 16'd2,   16'd0,   4'd8},  // R8 stage prescale
    '{OP_RD, 4'd2, 16'd0,   16'd100, 4'd8},  // R8 staged readback
    '{OP_AM, 4'd0, 16'd0,   16'd0,   4'd8},  // R8 not active yet
    '{OP_RL, 4'd0, 16'd0,   16'd0,   4'd1},  // R1 reload, flag 0
    '{OP_AM, 4'd0, 16'd0,   16'd0,   4'd1},  // R1 no transfer
    '{OP_WR, 4'd0, 16'd1,   16'd0,   4'd2},  // R2 write 1 unarmed
    '{OP_RD, 4'd0, 16'd0,   16'd0,   4'd2},  // R2 ignored; arms
    '{OP_WR, 4'd0, 16'd3,   16'd0,   4'd2},  // R2 set flag + enable
    '{OP_RD, 4'd0, 16'd0,   16'd3,   4'd2},  // R2 flag set
    '{OP_RL, 4'd0, 16'd0,   16'd0,   4'd1},  // R1 reload
    '{OP_AM, 4'd0, 16'd0,   16'd100, 4'd1},  // R1 modulus
    '{OP_AD, 4'd0, 16'd0,   16'd40,  4'd1},  // R1 duty ch0
    '{OP_AD, 4'd5, 16'd0,   16'd77,  4'd1},  // R1 duty ch5
    '{OP_AP, 4'd0, 16'd0,   16'd2,   4'd1},  // R1 prescale
    '{OP_RD, 4'd0, 16'd0,   16'd2,   4'd3},  // R3 auto clear; arms
    '{OP_WR, 4'd0, 16'd2,   16'd0,   4'd9},  // R9 intervening ctl write
    '{OP_WR, 4'd0, 16'd3,   16'd0,   4'd9},  // R9 stale write 1
    '{OP_RD, 4'd0, 16'd0,   16'd2,   4'd9},  // R9 ignored; arms
    '{OP_WR, 4'd2, 16'd200, 16'd0,   4'd4},  // R4 stage new modulus
    '{OP_WR, 4'd0, 16'd3,   16'd0,   4'd4},  // R4 set flag
    '{OP_RD, 4'd0, 16'd0,   16'd3,   4'd4},  // R4 flag set
    '{OP_WR, 4'd0, 16'd2,   16'd0,   4'd4},  // R4 cancel
    '{OP_RD, 4'd0, 16'd0,   16'd2,   4'd4},  // R4 flag clear; arms
    '{OP_RL, 4'd0, 16'd0,   16'd0,   4'd4},  // R4 reload
    '{OP_AM, 4'd0, 16'd0,   16'd100, 4'd4},  // R4 unchanged
    '{OP_WR, 4'd0, 16'd3,   16'd0,   4'd8},  // R8 set flag
    '{OP_WR, 4'd2, 16'd300, 16'd0,   4'd8},  // R8 stage while set
    '{OP_WR, 4'd3, 16'd9,   16'd0,   4'd8},  // R8 stage duty while set
    '{OP_RD, 4'd2, 16'd0,   16'd300, 4'd8},  // R8 readback
    '{OP_AM, 4'd0, 16'd0,   16'd100, 4'd8},  // R8 still old
    '{OP_RL, 4'd0, 16'd0,   16'd0,   4'd1},  // R1 reload
    '{OP_AM, 4'd0, 16'd0,   16'd300, 4'd8},  // R8 now active
    '{OP_AD, 4'd0, 16'd0,   16'd9,   4'd1},  // R1 duty ch0
    '{OP_AD, 4'd5, 16'd0,   16'd77,  4'd1},  // R1 ch5 kept
    '{OP_RD, 4'd0, 16'd0,   16'd2,   4'd3},  // R3 cleared, enable kept
    '{OP_RL, 4'd0, 16'd0,   16'd0,   4'd3},  // R3 reload, flag 0
    '{OP_AM, 4'd0, 16'd0,   16'd300, 4'd3}   // R3 no second transfer
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, reload = 1'b0, ovr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic [PS_W-1:0] act_ps;
  logic [MOD_W-1:0] act_mod;
  logic [N_CH*DUTY_W-1:0] act_duty;
  logic gen_run, irq;
  logic [2*N_CH-1:0] pin_oe;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_ctrl #(.N_CH(N_CH), .DUTY_W(DUTY_W), .MOD_W(MOD_W), .PS_W(PS_W),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pwm_reload_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reload_i(reload), .out_ovr_i(ovr),
    .act_prescale_o(act_ps), .act_modulus_o(act_mod), .act_duty_o(act_duty),
    .gen_run_o(gen_run), .pin_oe_o(pin_oe), .reload_irq_o(irq));

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; reload = 0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_tests++; n_fail++;
    $display("FAIL R0 watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    check(5, {16'd0, act_mod}, 0, "reset modulus");
    check(5, {20'd0, pin_oe}, 0, "reset oe");
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = 0; bus_rd = 1; #1;
    check(5, bus_rdata, 0, "reset ctl");
    bus_addr = 3; #1;
    check(5, bus_rdata, 0, "reset staged duty");
    @(posedge clk);

    for (int i = 0; i < N_ROWS; i++) begin
      @(negedge clk);
      idle();
      bus_addr = TBL[i].addr;
      bus_wdata = TBL[i].data;
      case (TBL[i].op)
        OP_WR: bus_wr = 1;
        OP_RD: begin bus_rd = 1; #1; check(TBL[i].req, bus_rdata, TBL[i].exp, "readback"); end
        OP_RL: reload = 1;
        OP_AM: check(TBL[i].req, act_mod, TBL[i].exp, "active modulus");
        OP_AD: check(TBL[i].req, act_duty[TBL[i].addr*DUTY_W +: DUTY_W], TBL[i].exp, "active duty");
        OP_AP: check(TBL[i].req, act_ps, TBL[i].exp, "active prescale");
        default: ;
      endcase
      @(posedge clk);
    end
    @(negedge clk); idle();

    // R7 enable set (from table), override low
    check(7, {20'd0, pin_oe}, 32'hFFF, "oe with enable");
    check(7, gen_run, 1, "run with enable");
    // R6 reload with flag 0 raises irq for one cycle
    reload = 1;
    @(negedge clk); reload = 0;
    check(6, irq, 1, "irq after reload");
    @(negedge clk);
    check(6, irq, 0, "irq one cycle");
    // R7 disable, override low
    bus_addr = 0; bus_wdata = 0; bus_wr = 1;
    @(negedge clk); idle();
    check(7, {20'd0, pin_oe}, 0, "oe disabled");
    check(7, gen_run, 0, "run disabled");
    ovr = 1; #1;
    check(7, {20'd0, pin_oe}, 32'hFFF, "oe override");
    ovr = 0;
    // R6 no irq while disabled
    reload = 1;
    @(negedge clk); reload = 0;
    check(6, irq, 0, "no irq disabled");
    // R5 set flag, then reset clears it
    bus_rd = 1; @(negedge clk); idle();
    bus_wdata = 16'd1; bus_wr = 1; @(negedge clk); idle();
    bus_rd = 1; #1;
    check(2, bus_rdata, 1, "flag set before reset");
    idle();
    rst_n = 0; #1;
    check(5, {16'd0, act_mod}, 0, "reset active modulus");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    bus_addr = 0; bus_rd = 1; #1;
    check(5, bus_rdata, 0, "flag after reset");
    bus_addr = 2; #1;
    check(5, bus_rdata, 0, "staged modulus after reset");
    idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule